// File: doc/BRIEF.md
# Flash Program Write-Combining Controller

This block sits between a processor write port and the program interface of a flash array. Flash cells are programmed in units wider than a single processor store, so the controller gathers 16-bit and 32-bit stores made to consecutive addresses into one programming unit. When the unit is complete it issues a single program request to the array. The unit width is 16, 32 or 64 bits and is chosen by a 2-bit select.

Wider units draw more programming current at once, so a 2-bit supply-range code caps the widest unit allowed. A unit whose first store is not aligned to the unit width, or whose later stores do not continue the address run, is thrown away and an error pulse is raised. A width that the present supply range does not allow raises a level error and holds the write port stalled until the selection is legal again. While the array is programming, the block reports busy for a fixed number of cycles and stalls further stores.

Setting the parameter `FIXED_CODE` to a nonzero width code builds a variant with a single fixed unit width. In that variant the select input is ignored.

Top module: `flash_wc_ctrl`

## Requirements
- R1: The width code on `unitSel` selects the unit size: 1 gives 2 bytes, 2 gives 4 bytes and 3 gives 8 bytes. Code 0 is never allowed and raises `parErr`. `progSize` reports the code of the unit being programmed.
- R2: A store with `wrStrb` = 4'b0011 is a 16-bit beat carrying `wrData[15:0]`. A store with `wrStrb` = 4'b1111 is a 32-bit beat carrying all of `wrData`. Any other strobe pattern pulses `seqErr`. The byte at address base+k lands in `progData[8k+7:8k]`, and bits above the unit width are zero.
- R3: Exactly one `progReq` pulse, one cycle long, appears in the cycle after the store that completes the unit. It carries `progAddr` = the first store's address. No request appears for a partial unit.
- R4: If the first store of a unit has an address that is not a multiple of the unit size, `seqErr` pulses for one cycle in the next cycle and no request is issued.
- R5: A later store that is not at base+bytes-collected, that would overrun the unit, or that is not aligned to its own beat size pulses `seqErr`. It also discards the partial unit, so the next store starts a new unit.
- R6: The supply-range code `vRange` caps the width code: 0 allows up to code 1, 1 allows up to code 2, and 2 or 3 allow code 3. While the selection is not allowed, `wrReady` is low, `parErr` is high from the next cycle on, and any partial unit is dropped.
- R7: `busy` rises together with `progReq` and stays high for exactly `PROG_CYCLES` cycles. `wrReady` is low throughout, so a store offered during busy waits exactly until busy falls.
- R8: After reset, `progReq`, `busy`, `seqErr` and `parErr` are low, and `wrReady` is high when the selection is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrValid | input | 1 | Processor store valid |
| wrAddr | input | ADDR_W | Store byte address |
| wrData | input | 32 | Store data, low-aligned |
| wrStrb | input | 4 | Byte strobes; 4'b0011 or 4'b1111 |
| wrReady | output | 1 | Store accepted on a clock edge where valid and ready are both high |
| unitSel | input | 2 | Unit width code |
| vRange | input | 2 | Supply range code |
| progReq | output | 1 | One-cycle program request |
| progAddr | output | ADDR_W | Unit start address |
| progData | output | 64 | Unit data |
| progSize | output | 2 | Width code of the programmed unit |
| busy | output | 1 | Array programming in progress |
| seqErr | output | 1 | One-cycle alignment or sequence error pulse |
| parErr | output | 1 | Width not allowed by supply range |

## Verification
A wrong byte count or a stale base address shows up on the very store that should complete a unit. Depending on the fault, the request then comes one beat early or late, carries a shifted address, or raises a false `seqErr`, all visible one cycle after that store. The tests therefore build every unit width from several beat mixes and compare the request, address and data in that cycle. A timer or state fault shows as a `busy` window of the wrong length, which the tests measure by counting stalled cycles of a waiting store. A partial unit that was not dropped after an error only shows on the next store, so each error test follows up with a store whose outcome depends on the count having been cleared.

// File: rtl/flash_wc_pkg.sv
package flash_wc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PROG = 2'd2
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic take;   // store accepted and legal
    logic first;  // store opens a new unit
    logic fire;   // store completes the unit
    logic drop;   // discard any partial unit
  } dpCtl_t;

  function automatic logic [3:0] unitBytes(input logic [1:0] code);
    case (code)
      2'd1:    unitBytes = 4'd2;
      2'd2:    unitBytes = 4'd4;
      2'd3:    unitBytes = 4'd8;
      default: unitBytes = 4'd0;
    endcase
  endfunction

  function automatic logic [1:0] maxCode(input logic [1:0] range);
    case (range)
      2'd0:    maxCode = 2'd1;
      2'd1:    maxCode = 2'd2;
      default: maxCode = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/flash_wc_dp.sv
module flash_wc_dp
  import flash_wc_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              beatWide,
  output logic [3:0]        fillCnt,
  output logic [ADDR_W-1:0] baseAddr,
  output logic [ADDR_W-1:0] progAddr,
  output logic [63:0]       progData
);

  logic [63:0] fillBuf;
  logic [63:0] beatVal;
  logic [63:0] nextBuf;
  logic [3:0]  beatBytes;

  always_comb begin
    beatVal   = beatWide ? {32'b0, wrData} : {48'b0, wrData[15:0]};
    beatBytes = beatWide ? 4'd4 : 4'd2;
    nextBuf   = (ctl.first ? 64'b0 : fillBuf) | (beatVal << {fillCnt[2:0], 3'b000});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fillBuf  <= '0;
      fillCnt  <= '0;
      baseAddr <= '0;
    end else if (ctl.drop) begin
      fillCnt <= '0;
    end else if (ctl.take) begin
      fillBuf <= nextBuf;
      if (ctl.first) baseAddr <= wrAddr;
      fillCnt <= ctl.fire ? 4'd0 : fillCnt + beatBytes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      progAddr <= '0;
      progData <= '0;
    end else if (ctl.take && ctl.fire) begin
      progData <= nextBuf;
      progAddr <= ctl.first ? wrAddr : baseAddr;
    end
  end

  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.drop |=> (fillCnt == 4'd0)); // R5

  AST_FIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.take && ctl.fire) |=> (fillCnt == 4'd0)); // R3

endmodule

// File: rtl/flash_wc_ctl.sv
module flash_wc_ctl
  import flash_wc_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int PROG_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [3:0]        wrStrb,
  input  logic [1:0]        selCode,
  input  logic [1:0]        vRange,
  input  logic [3:0]        fillCnt,
  input  logic [ADDR_W-1:0] baseAddr,
  output dpCtl_t            dpCtl,
  output logic              beatWide,
  output logic              wrReady,
  output logic              progReq,
  output logic [1:0]        progSize,
  output logic              busy,
  output logic              seqErr,
  output logic              parErr
);

  localparam int TMR_W = $clog2(PROG_CYCLES + 1);

  ctlState_e  state;
  logic [TMR_W-1:0] progTmr;
  logic [1:0] heldCode;
  logic [1:0] curCode;
  logic [3:0] ub;
  logic [3:0] bb;
  logic       allowed;
  logic       accept;
  logic       isFirst;
  logic       strbOk;
  logic       beatAlign;
  logic       unitAlign;
  logic       contig;
  logic       fits;
  logic       complete;
  logic       bad;

  always_comb begin
    allowed   = (selCode != 2'd0) && (selCode <= maxCode(vRange));
    isFirst   = (fillCnt == 4'd0);
    curCode   = isFirst ? selCode : heldCode;
    ub        = unitBytes(curCode);
    strbOk    = (wrStrb == 4'b1111) || (wrStrb == 4'b0011);
    beatWide  = (wrStrb == 4'b1111);
    bb        = beatWide ? 4'd4 : 4'd2;
    beatAlign = beatWide ? (wrAddr[1:0] == 2'b00) : (wrAddr[0] == 1'b0);
    unitAlign = (wrAddr[3:0] & (ub - 4'd1)) == 4'd0;
    contig    = (wrAddr == baseAddr + ADDR_W'(fillCnt));
    fits      = ({1'b0, fillCnt} + {1'b0, bb}) <= {1'b0, ub};
    complete  = (fillCnt + bb) == ub;
    bad       = !strbOk || !beatAlign || !fits || (isFirst ? !unitAlign : !contig);
    wrReady   = (state != ST_PROG) && allowed;
    accept    = wrValid && wrReady;
    dpCtl.take  = accept && !bad;
    dpCtl.first = isFirst;
    dpCtl.fire  = accept && !bad && complete;
    dpCtl.drop  = (accept && bad) || !allowed;
    busy        = (state == ST_PROG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      progTmr  <= '0;
      heldCode <= 2'd0;
      progSize <= 2'd0;
      progReq  <= 1'b0;
      seqErr   <= 1'b0;
      parErr   <= 1'b0;
    end else begin
      progReq <= dpCtl.fire;
      seqErr  <= accept && bad;
      parErr  <= !allowed;
      if (dpCtl.take && isFirst) heldCode <= selCode;
      case (state)
        ST_IDLE, ST_FILL: begin
          if (dpCtl.fire) begin
            state    <= ST_PROG;
            progTmr  <= TMR_W'(PROG_CYCLES - 1);
            progSize <= curCode;
          end else if (dpCtl.drop) begin
            state <= ST_IDLE;
          end else if (dpCtl.take) begin
            state <= ST_FILL;
          end
        end
        ST_PROG: begin
          if (progTmr == '0) state <= ST_IDLE;
          else progTmr <= progTmr - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    progReq |=> !progReq); // R3

  AST_REQ_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    progReq |-> busy); // R7

  AST_STALL_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wrReady); // R7

  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    seqErr |-> !progReq); // R4

  AST_PAR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (parErr && $stable(selCode) && $stable(vRange)) |-> !wrReady); // R6

endmodule

// File: rtl/flash_wc_ctrl.sv
module flash_wc_ctrl
  import flash_wc_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int PROG_CYCLES = 6,
  parameter int FIXED_CODE  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [3:0]        wrStrb,
  output logic              wrReady,
  input  logic [1:0]        unitSel,
  input  logic [1:0]        vRange,
  output logic              progReq,
  output logic [ADDR_W-1:0] progAddr,
  output logic [63:0]       progData,
  output logic [1:0]        progSize,
  output logic              busy,
  output logic              seqErr,
  output logic              parErr
);

  dpCtl_t            dpCtl;
  logic              beatWide;
  logic [3:0]        fillCnt;
  logic [ADDR_W-1:0] baseAddr;
  logic [1:0]        selCode;

  generate
    if (FIXED_CODE != 0) begin : g_fixed
      assign selCode = 2'(FIXED_CODE);
    end else begin : g_select
      assign selCode = unitSel;
    end
  endgenerate

  flash_wc_ctl #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrValid  (wrValid),
    .wrAddr   (wrAddr),
    .wrStrb   (wrStrb),
    .selCode  (selCode),
    .vRange   (vRange),
    .fillCnt  (fillCnt),
    .baseAddr (baseAddr),
    .dpCtl    (dpCtl),
    .beatWide (beatWide),
    .wrReady  (wrReady),
    .progReq  (progReq),
    .progSize (progSize),
    .busy     (busy),
    .seqErr   (seqErr),
    .parErr   (parErr)
  );

  flash_wc_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (dpCtl),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .beatWide (beatWide),
    .fillCnt  (fillCnt),
    .baseAddr (baseAddr),
    .progAddr (progAddr),
    .progData (progData)
  );

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    progReq |-> ((progAddr[3:0] & (unitBytes(progSize) - 4'd1)) == 4'd0)); // R4

endmodule

// File: tb/flash_wc_ctrl_tb.sv
module flash_wc_ctrl_tb;

  localparam int ADDR_W = 24;
  localparam int PROG_CYCLES = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wrValid = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [31:0]       wrData = '0;
  logic [3:0]        wrStrb = 4'b0000;
  logic              wrReady;
  logic [1:0]        unitSel = 2'd1;
  logic [1:0]        vRange = 2'd3;
  logic              progReq;
  logic [ADDR_W-1:0] progAddr;
  logic [63:0]       progData;
  logic [1:0]        progSize;
  logic              busy;
  logic              seqErr;
  logic              parErr;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  flash_wc_ctrl #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_dut (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .wrStrb(wrStrb), .wrReady(wrReady), .unitSel(unitSel),
    .vRange(vRange), .progReq(progReq), .progAddr(progAddr),
    .progData(progData), .progSize(progSize), .busy(busy),
    .seqErr(seqErr), .parErr(parErr)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive a store at a negedge; returns at the negedge after acceptance
  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                         input logic [3:0] s, output int stalls);
    wrValid = 1'b1; wrAddr = a; wrData = d; wrStrb = s;
    stalls = 0;
    #1;
    while (!wrReady) begin
      stalls++;
      @(negedge clk); #1;
    end
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R8 progReq", progReq, 0);
    chk("R8 busy", busy, 0);
    chk("R8 seqErr", seqErr, 0);
    chk("R8 parErr", parErr, 0);
    chk("R8 wrReady", wrReady, 1);
  endtask

  task automatic t_half();
    int st;
    int bcnt;
    unitSel = 2'd1;
    doWrite(24'h000100, 32'h0000BEEF, 4'b0011, st);
    chk("R3 req", progReq, 1);
    chk("R3 addr", progAddr, 24'h000100);
    chk("R2 data16", progData, 64'hBEEF);
    chk("R1 size", progSize, 2'd1);
    bcnt = 0;
    while (busy) begin bcnt++; @(negedge clk); end
    chk("R7 busy length", bcnt, PROG_CYCLES);
    chk("R3 single pulse", progReq, 0);
  endtask

  task automatic t_word16x2();
    int st;
    unitSel = 2'd2;
    doWrite(24'h000200, 32'h00001111, 4'b0011, st);
    chk("R3 no early req", progReq, 0);
    doWrite(24'h000202, 32'h00002222, 4'b0011, st);
    chk("R3 req word", progReq, 1);
    chk("R3 addr word", progAddr, 24'h000200);
    chk("R2 data word", progData, 64'h22221111);
    chk("R1 size word", progSize, 2'd2);
    waitIdle();
  endtask

  task automatic t_dword_stall();
    int st;
    unitSel = 2'd3;
    doWrite(24'h000308, 32'hAAAA5555, 4'b1111, st);
    chk("R3 no early dword", progReq, 0);
    doWrite(24'h00030C, 32'h12345678, 4'b1111, st);
    chk("R3 req dword", progReq, 1);
    chk("R2 data dword", progData, 64'h12345678AAAA5555);
    chk("R1 size dword", progSize, 2'd3);
    doWrite(24'h000400, 32'hCAFEF00D, 4'b1111, st);
    chk("R7 stall cycles", st, PROG_CYCLES);
    doWrite(24'h000404, 32'h0BADBEEF, 4'b1111, st);
    chk("R7 after stall req", progReq, 1);
    chk("R7 after stall data", progData, 64'h0BADBEEFCAFEF00D);
    waitIdle();
  endtask

  task automatic t_mixed();
    int st;
    unitSel = 2'd3;
    doWrite(24'h000500, 32'h03020100, 4'b1111, st);
    doWrite(24'h000504, 32'h00000504, 4'b0011, st);
    chk("R3 no req at 6 bytes", progReq, 0);
    doWrite(24'h000506, 32'h00000706, 4'b0011, st);
    chk("R2 mixed beats", progData, 64'h0706050403020100);
    chk("R3 mixed addr", progAddr, 24'h000500);
    waitIdle();
  endtask

  task automatic t_misaligned();
    int st;
    unitSel = 2'd2;
    doWrite(24'h000602, 32'h00001234, 4'b0011, st);
    chk("R4 seqErr", seqErr, 1);
    chk("R4 no req", progReq, 0);
    @(negedge clk);
    chk("R4 seqErr pulse", seqErr, 0);
    doWrite(24'h000604, 32'h00005678, 4'b0011, st);
    chk("R4 restart no req", progReq, 0);
    doWrite(24'h000606, 32'h00009ABC, 4'b0011, st);
    chk("R4 restart data", progData, 64'h9ABC5678);
    chk("R4 restart addr", progAddr, 24'h000604);
    waitIdle();
  endtask

  task automatic t_noncontig();
    int st;
    unitSel = 2'd3;
    doWrite(24'h000700, 32'h11111111, 4'b1111, st);
    doWrite(24'h000708, 32'h22222222, 4'b1111, st);
    chk("R5 gap seqErr", seqErr, 1);
    chk("R5 gap no req", progReq, 0);
    doWrite(24'h000708, 32'h33333333, 4'b1111, st);
    chk("R5 partial dropped", progReq, 0);
    chk("R5 fresh start no err", seqErr, 0);
    doWrite(24'h00070C, 32'h44444444, 4'b1111, st);
    chk("R5 fresh addr", progAddr, 24'h000708);
    chk("R5 fresh data", progData, 64'h4444444433333333);
    waitIdle();
  endtask

  task automatic t_overrun();
    int st;
    unitSel = 2'd1;
    doWrite(24'h000800, 32'hDEADBEEF, 4'b1111, st);
    chk("R5 overrun seqErr", seqErr, 1);
    chk("R5 overrun no req", progReq, 0);
    doWrite(24'h000800, 32'h00000055, 4'b0001, st);
    chk("R2 bad strobe seqErr", seqErr, 1);
    chk("R2 bad strobe no req", progReq, 0);
    unitSel = 2'd3;
    doWrite(24'h000810, 32'h00000001, 4'b0011, st);
    doWrite(24'h000813, 32'h00000002, 4'b0011, st);
    chk("R5 beat misalign seqErr", seqErr, 1);
  endtask

  task automatic t_volt();
    int st;
    @(negedge clk);
    unitSel = 2'd3; vRange = 2'd3;
    doWrite(24'h000900, 32'h01010101, 4'b1111, st);
    vRange = 2'd1;
    #1;
    chk("R6 ready low", wrReady, 0);
    @(negedge clk);
    chk("R6 parErr dword at range1", parErr, 1);
    vRange = 2'd3;
    @(negedge clk);
    chk("R6 parErr clears", parErr, 0);
    doWrite(24'h000904, 32'h02020202, 4'b1111, st);
    chk("R6 partial dropped", seqErr, 1);
    vRange = 2'd0; unitSel = 2'd2;
    @(negedge clk);
    chk("R6 word at range0", parErr, 1);
    vRange = 2'd1;
    @(negedge clk);
    chk("R6 word at range1", parErr, 0);
    chk("R6 ready back", wrReady, 1);
    vRange = 2'd0; unitSel = 2'd1;
    @(negedge clk);
    chk("R6 half at range0", parErr, 0);
    unitSel = 2'd0;
    @(negedge clk);
    chk("R1 code0 parErr", parErr, 1);
    unitSel = 2'd1; vRange = 2'd3;
    @(negedge clk);
  endtask

  initial begin
    wait (cyc >= 100000);
    fails++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    @(negedge clk);
    t_half();
    t_word16x2();
    t_dword_stall();
    t_mixed();
    t_misaligned();
    t_noncontig();
    t_overrun();
    t_volt();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule